// File: doc/BRIEF.md
# Cascadable Serial Codec Control Port

This block is the serial control and data port of one codec in a daisy chain of identical codecs sharing a frame-synchronised 16-bit serial link. Words arrive bit-serially on `sdi` after a frame pulse on `sdifs`. Each complete word is decoded. A control word aimed at this device either writes one of eight 8-bit configuration registers or, for a read, has its data byte replaced with the register contents. A control word aimed further down the chain is passed on with its hop count reduced by one. Forwarded words leave on `sdo`, each preceded by a one-cycle pulse on `sdofs`.

When no forwarded word is waiting, the port sends captured converter samples. These samples are zeroed while the device is still in program mode. Once register 0 bit 0 selects data mode, incoming data words are loaded into the DAC data register. A synchronous reset clears the register bank and returns the port to program mode. `clk` is the serial bit clock, and one bit is moved per cycle in each direction.

Top module: `ccp_top`

## Requirements
- R1: After reset, all eight configuration registers read 0, `prog_mode` is 1, `sdofs` is 0 and `dac_word` is 0.
- R2: A word's fields are bit 15 control (1) / data (0), bit 14 read (1) / write (0), bits 13:11 device hop count, bits 10:8 register index and bits 7:0 data. A control write with hop count 000 stores the data byte in the selected register and is not forwarded.
- R3: A control word with a non-zero hop count is forwarded with the hop count reduced by one and every other bit unchanged.
- R4: A control read with hop count 000 is forwarded with hop count 111 and its data byte replaced by the selected register's contents. All other bits are unchanged.
- R5: A control read with a non-zero hop count is forwarded with its data byte unchanged and its hop count reduced by one.
- R6: A sample captured on `adc_strobe` while `prog_mode` is 1 is sent as 16'h0000.
- R7: A sample captured while in data mode is sent unchanged. Data mode is register 0 bit 0 equal to 1.
- R8: In data mode, a data word (bit 15 = 0) is loaded into `dac_word` with a one-cycle `dac_load` pulse. In program mode, a data word leaves `dac_word` unchanged, gives no pulse and is not forwarded.
- R9: Every outgoing word is a single-cycle `sdofs` pulse, followed by its 16 bits on `sdo`, MSB first, one per following cycle.
- R10: When a forwarded word and a sample are both waiting for the transmitter, the forwarded word goes first.
- R11: A synchronous reset asserted after registers were written clears them and returns the port to program mode.
- R12: `sdi` activity without an `sdifs` pulse is not captured. It produces no output frame, no register change and no DAC load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data in |
| sdifs | input | 1 | Input frame pulse; the word's MSB follows in the next cycle |
| sdo | output | 1 | Serial data out |
| sdofs | output | 1 | Output frame pulse; the word's MSB follows in the next cycle |
| adc_word | input | 16 | Converter sample to be sent |
| adc_strobe | input | 1 | One-cycle pulse capturing `adc_word` |
| dac_word | output | 16 | DAC data register |
| dac_load | output | 1 | One-cycle pulse when `dac_word` is updated |
| prog_mode | output | 1 | 1 while the port is in program mode |
| cfg_regs | output | 64 | Register bank; register n occupies bits 8n+7:8n |

## Verification
The assertions take for granted three things about the inputs. A new input frame never starts before the previous 16 bits are in. The sender never delivers a second forwardable word while the first still waits behind a busy transmitter. `adc_strobe` comes no faster than the transmitter can drain samples. The stimulus keeps within these limits by spacing every input word by at least two full frame times. In the priority test, only one sample and one word overlap a busy frame.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int WORD_W = 16;
    localparam int HOP_W  = 3;
    localparam int IDX_W  = 3;
    localparam int BYTE_W = 8;
    localparam int NREG   = 1 << IDX_W;

    typedef struct packed {
        logic              ctl;
        logic              rd;
        logic [HOP_W-1:0]  hop;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] dat;
    } ccp_word_t;
endpackage

// File: rtl/ccp_rx_deser.sv
module ccp_rx_deser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi,
    input  logic         sdifs,
    output logic [W-1:0] word,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  shreg;
        logic [W-1:0]  word;
        logic          valid;
    } rx_state_t;

    rx_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        s_d.valid = 1'b0;
        if (s_q.cnt == '0) begin
            if (sdifs) s_d.cnt = CW'(W);
        end else begin
            s_d.shreg = {s_q.shreg[W-2:0], sdi};
            s_d.cnt   = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.word  = {s_q.shreg[W-2:0], sdi};
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign word  = s_q.word;
    assign valid = s_q.valid;

    // R12
    rx_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(s_q.cnt) == '0 && !$past(sdifs) && !$past(rst)) |-> (s_q.cnt == '0));
endmodule

// File: rtl/ccp_regbank.sv
module ccp_regbank #(
    parameter int NR = 8,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [$clog2(NR)-1:0] waddr,
    input  logic [DW-1:0]         wdata,
    input  logic [$clog2(NR)-1:0] raddr,
    output logic [DW-1:0]         rdata,
    output logic [NR*DW-1:0]      flat
);
    logic [DW-1:0] regs_q [NR];
    logic [DW-1:0] regs_d [NR];

    always_comb begin
        for (int i = 0; i < NR; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    assign rdata = regs_q[raddr];

    for (genvar g = 0; g < NR; g++) begin : g_flat
        assign flat[g*DW +: DW] = regs_q[g];
    end

    // R11
    regs_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (flat == '0));
endmodule

// File: rtl/ccp_tx_ser.sv
module ccp_tx_ser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd_req,
    input  logic [W-1:0] fwd_word,
    input  logic         smp_req,
    input  logic [W-1:0] smp_word,
    output logic         fwd_take,
    output logic         smp_take,
    output logic         sdo,
    output logic         sdofs
);
    localparam int FRAME = W + 1;
    localparam int CW    = $clog2(FRAME + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  shreg;
    } tx_state_t;

    tx_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        fwd_take = 1'b0;
        smp_take = 1'b0;
        if (s_q.cnt == '0) begin
            if (fwd_req) begin
                fwd_take  = 1'b1;
                s_d.shreg = fwd_word;
                s_d.cnt   = CW'(FRAME);
            end else if (smp_req) begin
                smp_take  = 1'b1;
                s_d.shreg = smp_word;
                s_d.cnt   = CW'(FRAME);
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt != CW'(FRAME)) s_d.shreg = {s_q.shreg[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sdofs = (s_q.cnt == CW'(FRAME));
    assign sdo   = (s_q.cnt != '0) && !sdofs && s_q.shreg[W-1];

    // R9
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sdofs |=> !sdofs);
    // R9
    tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (sdofs && !$past(rst)) |-> ($past(s_q.cnt) == '0));
    // R10
    prio_chk: assert property (@(posedge clk) disable iff (rst)
        !(fwd_take && smp_take));
endmodule

// File: rtl/ccp_top.sv
module ccp_top
    import ccp_pkg::*;
#(
    parameter int W  = ccp_pkg::WORD_W,
    parameter int NR = ccp_pkg::NREG,
    parameter int DW = ccp_pkg::BYTE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sdi,
    input  logic           sdifs,
    output logic           sdo,
    output logic           sdofs,
    input  logic [W-1:0]   adc_word,
    input  logic           adc_strobe,
    output logic [W-1:0]   dac_word,
    output logic           dac_load,
    output logic           prog_mode,
    output logic [NR*DW-1:0] cfg_regs
);
    localparam int IW = $clog2(NR);

    logic [W-1:0]  rx_word;
    logic          rx_valid;
    ccp_word_t     rxw;
    logic [DW-1:0] rd_byte;
    logic          fwd_take, smp_take;
    logic          wr_en;
    logic          fwd_need;

    typedef struct packed {
        logic          fwd_pend;
        logic [W-1:0]  fwd_word;
        logic          smp_pend;
        logic [W-1:0]  smp_word;
        logic [W-1:0]  dac;
        logic          load;
    } top_state_t;

    top_state_t s_q, s_d;

    ccp_rx_deser #(.W(W)) rx_i (
        .clk(clk), .rst(rst), .sdi(sdi), .sdifs(sdifs),
        .word(rx_word), .valid(rx_valid)
    );

    assign rxw = ccp_word_t'(rx_word);

    ccp_regbank #(.NR(NR), .DW(DW)) regs_i (
        .clk(clk), .rst(rst), .we(wr_en),
        .waddr(IW'(rxw.idx)), .wdata(rxw.dat),
        .raddr(IW'(rxw.idx)), .rdata(rd_byte), .flat(cfg_regs)
    );

    assign prog_mode = !cfg_regs[0];

    always_comb begin
        ccp_word_t fw;
        s_d      = s_q;
        s_d.load = 1'b0;
        wr_en    = rx_valid && rxw.ctl && !rxw.rd && (rxw.hop == '0);
        fwd_need = rx_valid && rxw.ctl && (rxw.rd || (rxw.hop != '0));

        fw     = rxw;
        fw.hop = rxw.hop - 1'b1;
        if (rxw.rd && rxw.hop == '0) fw.dat = rd_byte;

        if (fwd_take) s_d.fwd_pend = 1'b0;
        if (fwd_need) begin
            s_d.fwd_pend = 1'b1;
            s_d.fwd_word = fw;
        end

        if (smp_take) s_d.smp_pend = 1'b0;
        if (adc_strobe) begin
            s_d.smp_pend = 1'b1;
            s_d.smp_word = prog_mode ? '0 : adc_word;
        end

        if (rx_valid && !rxw.ctl && !prog_mode) begin
            s_d.dac  = rx_word;
            s_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    ccp_tx_ser #(.W(W)) tx_i (
        .clk(clk), .rst(rst),
        .fwd_req(s_q.fwd_pend), .fwd_word(s_q.fwd_word),
        .smp_req(s_q.smp_pend), .smp_word(s_q.smp_word),
        .fwd_take(fwd_take), .smp_take(smp_take),
        .sdo(sdo), .sdofs(sdofs)
    );

    assign dac_word = s_q.dac;
    assign dac_load = s_q.load;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (prog_mode && !sdofs && dac_word == '0));
    // R6
    adc_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_strobe && prog_mode) |=> (s_q.smp_word == '0));
    // R8
    dac_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_load && !$past(rst)) |-> !$past(prog_mode));
    // R2
    no_fwd_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(s_q.fwd_word));
    // R10
    no_fwd_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_need |-> (!s_q.fwd_pend || fwd_take));
endmodule

// File: tb/ccp_top_tb_top.sv
module ccp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi = 1'b0;
    logic        sdifs = 1'b0;
    logic        sdo, sdofs;
    logic [15:0] adc_word = '0;
    logic        adc_strobe = 1'b0;
    logic [15:0] dac_word;
    logic        dac_load;
    logic        prog_mode;
    logic [63:0] cfg_regs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] log_w [64];
    int          nlog = 0;
    int          nload = 0;
    int          mon_cnt = 0;
    logic [15:0] mon_sh;
    logic        prev_fs = 1'b0;

    always #5 clk = ~clk;

    ccp_top dut_i (
        .clk(clk), .rst(rst), .sdi(sdi), .sdifs(sdifs), .sdo(sdo), .sdofs(sdofs),
        .adc_word(adc_word), .adc_strobe(adc_strobe), .dac_word(dac_word),
        .dac_load(dac_load), .prog_mode(prog_mode), .cfg_regs(cfg_regs)
    );

    // frame monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            mon_cnt = 0;
            prev_fs = 1'b0;
        end else begin
            checks++;
            if (sdofs && prev_fs) begin
                fails++;
                $display("FAIL R9: sdofs wider than one cycle act=1 exp=0");
            end
            prev_fs = sdofs;
            if (dac_load) nload++;
            if (mon_cnt > 0) begin
                mon_sh = {mon_sh[14:0], sdo};
                mon_cnt--;
                if (mon_cnt == 0 && nlog < 64) begin
                    log_w[nlog] = mon_sh;
                    nlog++;
                end
            end else if (sdofs) begin
                mon_cnt = 16;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        sdifs = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            sdifs = 1'b0;
            sdi   = w[i];
        end
        @(negedge clk);
        sdi = 1'b0;
    endtask

    task automatic settle();
        repeat (45) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] v);
        @(negedge clk);
        adc_word   = v;
        adc_strobe = 1'b1;
        @(negedge clk);
        adc_strobe = 1'b0;
    endtask

    // {input word, forwarded?, expected forwarded word}
    localparam logic [32:0] VEC [0:6] = '{
        {16'h82A5, 1'b0, 16'h0000},  // R2 write reg2 = A5
        {16'hC200, 1'b1, 16'hFAA5},  // R4 read reg2
        {16'h8B3C, 1'b1, 16'h833C},  // R3 write for next device
        {16'hD511, 1'b1, 16'hCD11},  // R5 read for device two hops on
        {16'hB8FF, 1'b1, 16'hB0FF},  // R3 hop 111 -> 110
        {16'h8001, 1'b0, 16'h0000},  // R2 reg0 bit0 -> data mode
        {16'hC000, 1'b1, 16'hF801}   // R4 read reg0
    };

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(cfg_regs == '0, "R1 regs", cfg_regs, 0);
        check(prog_mode == 1'b1, "R1 prog_mode", prog_mode, 1);
        check(sdofs == 1'b0, "R1 sdofs", sdofs, 0);
        check(dac_word == '0, "R1 dac_word", dac_word, 0);

        // R6: sample muted in program mode
        n0 = nlog;
        strobe(16'h1234);
        settle();
        check(nlog == n0 + 1, "R6 frame count", nlog, n0 + 1);
        check(log_w[n0] == 16'h0000, "R6 muted sample", log_w[n0], 16'h0000);

        // R8: data word in program mode ignored
        n0 = nlog;
        send_word(16'h1234);
        settle();
        check(dac_word == '0 && nload == 0, "R8 prog ignore", dac_word, 0);
        check(nlog == n0, "R8 no forward", nlog, n0);

        // R12: sdi toggling without frame pulse
        n0 = nlog;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            sdi = i[0] ^ i[2];
        end
        sdi = 1'b0;
        settle();
        check(nlog == n0, "R12 no frame", nlog, n0);
        check(cfg_regs == '0 && nload == 0, "R12 no effect", cfg_regs, 0);

        // table walk (R2, R3, R4, R5, R9)
        for (int v = 0; v < 7; v++) begin
            n0 = nlog;
            send_word(VEC[v][32:17]);
            settle();
            if (VEC[v][16]) begin
                check(nlog == n0 + 1, "R3/R4/R5 forwarded", nlog, n0 + 1);
                check(log_w[n0] == VEC[v][15:0], "R9 forwarded word", log_w[n0], VEC[v][15:0]);
            end else begin
                check(nlog == n0, "R2 consumed", nlog, n0);
            end
        end
        check(cfg_regs[23:16] == 8'hA5, "R2 reg2", cfg_regs[23:16], 8'hA5);
        check(prog_mode == 1'b0, "R7 data mode", prog_mode, 0);

        // R7: sample passed in data mode
        n0 = nlog;
        strobe(16'h5A5A);
        settle();
        check(log_w[n0] == 16'h5A5A, "R7 sample", log_w[n0], 16'h5A5A);

        // R8: data word loads DAC in data mode
        send_word(16'h2345);
        settle();
        check(dac_word == 16'h2345, "R8 dac_word", dac_word, 16'h2345);
        check(nload == 1, "R8 dac_load pulses", nload, 1);

        // R10: forwarded word beats a waiting sample
        n0 = nlog;
        fork
            send_word(16'hB8FF);
            begin
                @(negedge clk);
                adc_word = 16'h1111; adc_strobe = 1'b1;
                @(negedge clk);
                adc_strobe = 1'b0;
                @(negedge clk);
                adc_word = 16'h2222; adc_strobe = 1'b1;
                @(negedge clk);
                adc_strobe = 1'b0;
            end
        join
        repeat (70) @(negedge clk);
        check(nlog == n0 + 3, "R10 frame count", nlog, n0 + 3);
        check(log_w[n0] == 16'h1111, "R10 first", log_w[n0], 16'h1111);
        check(log_w[n0+1] == 16'hB0FF, "R10 forward first", log_w[n0+1], 16'hB0FF);
        check(log_w[n0+2] == 16'h2222, "R10 sample after", log_w[n0+2], 16'h2222);

        // R11: reset after writes
        send_word(16'h8477);
        settle();
        n0 = nlog;
        send_word(16'hC400);
        settle();
        check(log_w[n0] == 16'hFC77, "R11 pre-reset read", log_w[n0], 16'hFC77);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_regs == '0, "R11 regs cleared", cfg_regs, 0);
        check(prog_mode == 1'b1, "R11 prog_mode", prog_mode, 1);
        n0 = nlog;
        send_word(16'hC400);
        settle();
        check(log_w[n0] == 16'hFC00, "R11 post-reset read", log_w[n0], 16'hFC00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule